// File: doc/BRIEF.md
# Three-Level Block Transfer Address Sequencer

This block holds one transfer descriptor and turns it into a stream of row requests for a memory mover. The descriptor has three counts: an element size in bytes, a number of rows per frame and a number of frames. It also has four signed steps: a row step and a frame step, each given separately for the source and for the destination. Each sync pulse moves one whole frame. The block then issues one request per row, one per clock. Each request carries the source address, the destination address and the byte count.

After a frame the stored descriptor is rewritten in place. Both base addresses advance by their frame steps and the frame count drops by one. A frame-done pulse marks every frame except the last, and a transfer-done pulse marks the last frame. Each pulse has its own enable. A static flag stops the rewrite. A transfer with several frames then replays its first frame on every sync and never reaches its end. A sync that arrives while a frame is running is held and serviced when that frame ends.

Top module: `dma3d_seq`

## Requirements
- R1: A load pulse while `busy_o` is low stores the whole descriptor, and `frames_left_o` then shows the loaded frame count. A load pulse while `busy_o` is high is ignored.
- R2: A sync sampled while idle with non-zero counts produces requests on exactly B consecutive cycles. The first request is in the cycle after the sync edge, and `req_bytes_o` equals the A count.
- R3: The request for row r carries source base + r × source row step and destination base + r × destination row step. Steps are sign-extended 16-bit values and the sums wrap at the address width.
- R4: With the static flag clear, each finished frame adds the sign-extended frame steps to both stored bases and decrements the stored frame count.
- R5: With its enable set, `frame_done_o` pulses for one cycle, in the cycle after the last request of a frame whose stored frame count was not 1.
- R6: With its enable set, `xfer_done_o` pulses for one cycle after the last request of a frame whose stored frame count was 1. With either enable clear, the matching pulse never appears.
- R7: With the static flag set, the stored descriptor never changes. Every sync repeats the same frame addresses, and `frames_left_o` keeps its value.
- R8: A sync taken while any of the A, B or C counts is zero issues no request, and `xfer_done_o` pulses in the next cycle if its enable is set.
- R9: A sync that arrives while busy is latched and serviced immediately after the current frame. Several syncs during one frame merge into a single pending one.
- R10: After reset there are no requests and no pulses, `busy_o` is low and `frames_left_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Descriptor load strobe |
| ld_src_i | input | AW | Source base address |
| ld_dst_i | input | AW | Destination base address |
| ld_acnt_i | input | CW | Bytes per row |
| ld_bcnt_i | input | CW | Rows per frame |
| ld_ccnt_i | input | CW | Frames per transfer |
| ld_src_bstep_i | input | SW | Signed source row step |
| ld_dst_bstep_i | input | SW | Signed destination row step |
| ld_src_cstep_i | input | SW | Signed source frame step |
| ld_dst_cstep_i | input | SW | Signed destination frame step |
| ld_static_i | input | 1 | Suppress descriptor rewrite |
| ld_mid_en_i | input | 1 | Enable for the frame-done pulse |
| ld_end_en_i | input | 1 | Enable for the transfer-done pulse |
| sync_i | input | 1 | Frame sync event |
| req_valid_o | output | 1 | Row request valid |
| req_src_o | output | AW | Row source address |
| req_dst_o | output | AW | Row destination address |
| req_bytes_o | output | CW | Row byte count |
| frame_done_o | output | 1 | Intermediate completion pulse |
| xfer_done_o | output | 1 | Final completion pulse |
| frames_left_o | output | CW | Stored frame count |
| busy_o | output | 1 | Frame running or sync pending |

## Verification
A corrupted row accumulator shows up on the second request of a frame, one cycle after the frame starts. A wrong frame rewrite stays hidden until the next sync, and then every request of that frame is off by the frame step. A lost pending sync costs a whole frame: its requests and its pulse never appear, and the scoreboard is left with items it never received. A wrong frame count shows at `frames_left_o` as soon as the frame ends, and at the frame after that the wrong kind of completion pulse appears.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_src_i,
  input  logic [AW-1:0] ld_dst_i,
  input  logic [CW-1:0] ld_acnt_i,
  input  logic [CW-1:0] ld_bcnt_i,
  input  logic [CW-1:0] ld_ccnt_i,
  input  logic [SW-1:0] ld_src_bstep_i,
  input  logic [SW-1:0] ld_dst_bstep_i,
  input  logic [SW-1:0] ld_src_cstep_i,
  input  logic [SW-1:0] ld_dst_cstep_i,
  input  logic          ld_static_i,
  input  logic          ld_mid_en_i,
  input  logic          ld_end_en_i,
  input  logic          sync_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_src_o,
  output logic [AW-1:0] req_dst_o,
  output logic [CW-1:0] req_bytes_o,
  output logic          frame_done_o,
  output logic          xfer_done_o,
  output logic [CW-1:0] frames_left_o,
  output logic          busy_o
);
  localparam int EXT = AW - SW;

  logic [AW-1:0] d_src, d_dst, cur_src, cur_dst;
  logic [CW-1:0] d_acnt, d_bcnt, d_ccnt, row;
  logic [SW-1:0] d_sb, d_db, d_sc, d_dc;
  logic          d_static, d_mid, d_end;
  logic          run, pend, mid_q, end_q;

  function automatic logic [AW-1:0] sx(input logic [SW-1:0] v);
    return {{EXT{v[SW-1]}}, v};
  endfunction

  logic start, zero, last_row, last_frame, ld_acc, pend_n;

  assign busy_o     = run | pend;
  assign ld_acc     = ld_i & ~busy_o;
  assign start      = ~run & (sync_i | pend);
  assign zero       = (d_acnt == '0) | (d_bcnt == '0) | (d_ccnt == '0);
  assign last_row   = run & (row == d_bcnt - 1'b1);
  assign last_frame = (d_ccnt == 1);
  assign pend_n     = start ? (pend & sync_i) : (pend | (run & sync_i));

  assign req_valid_o   = run;
  assign req_src_o     = cur_src;
  assign req_dst_o     = cur_dst;
  assign req_bytes_o   = d_acnt;
  assign frame_done_o  = mid_q;
  assign xfer_done_o   = end_q;
  assign frames_left_o = d_ccnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_src <= '0; d_dst <= '0; d_acnt <= '0; d_bcnt <= '0; d_ccnt <= '0;
      d_sb <= '0; d_db <= '0; d_sc <= '0; d_dc <= '0;
      d_static <= 1'b0; d_mid <= 1'b0; d_end <= 1'b0;
      run <= 1'b0; pend <= 1'b0; mid_q <= 1'b0; end_q <= 1'b0;
      row <= '0; cur_src <= '0; cur_dst <= '0;
    end else begin
      mid_q <= 1'b0;
      end_q <= 1'b0;
      pend  <= pend_n;
      if (ld_acc) begin
        d_src <= ld_src_i;        d_dst <= ld_dst_i;
        d_acnt <= ld_acnt_i;      d_bcnt <= ld_bcnt_i;  d_ccnt <= ld_ccnt_i;
        d_sb <= ld_src_bstep_i;   d_db <= ld_dst_bstep_i;
        d_sc <= ld_src_cstep_i;   d_dc <= ld_dst_cstep_i;
        d_static <= ld_static_i;  d_mid <= ld_mid_en_i; d_end <= ld_end_en_i;
      end
      if (start) begin
        if (zero) begin
          end_q <= d_end;
        end else begin
          run     <= 1'b1;
          row     <= '0;
          cur_src <= d_src;
          cur_dst <= d_dst;
        end
      end else if (run) begin
        if (last_row) begin
          run   <= 1'b0;
          mid_q <= d_mid & ~last_frame;
          end_q <= d_end & last_frame;
          if (!d_static) begin
            d_src  <= d_src + sx(d_sc);
            d_dst  <= d_dst + sx(d_dc);
            d_ccnt <= d_ccnt - 1'b1;
          end
        end else begin
          row     <= row + 1'b1;
          cur_src <= cur_src + sx(d_sb);
          cur_dst <= cur_dst + sx(d_db);
        end
      end
    end
  end
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          sync,
  input logic          frame_done,
  input logic          xfer_done,
  input logic [CW-1:0] frames_left,
  input logic          ld_acc
);
  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  a_r6_one_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && xfer_done));

  a_r5_mid_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(req_valid));

  a_r4_count_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(frames_left) && !$past(ld_acc)) |-> $fell(req_valid));

  a_r9_sync_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sync) |=> busy);
endmodule

bind dma3d_seq dma3d_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid_o), .busy(busy_o),
  .sync(sync_i), .frame_done(frame_done_o), .xfer_done(xfer_done_o),
  .frames_left(frames_left_o), .ld_acc(ld_acc)
);

// File: tb/sim_dma3d_seq.sv
module sim_dma3d_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ld_i = 1'b0, sync_i = 1'b0;
  logic [31:0] ld_src_i = '0, ld_dst_i = '0;
  logic [15:0] ld_acnt_i = '0, ld_bcnt_i = '0, ld_ccnt_i = '0;
  logic [15:0] ld_sb = '0, ld_db = '0, ld_sc = '0, ld_dc = '0;
  logic        ld_static_i = 1'b0, ld_mid_i = 1'b0, ld_end_i = 1'b0;
  logic        req_valid_o, frame_done_o, xfer_done_o, busy_o;
  logic [31:0] req_src_o, req_dst_o;
  logic [15:0] req_bytes_o, frames_left_o;

  dma3d_seq u0 (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ld_src_i(ld_src_i), .ld_dst_i(ld_dst_i),
    .ld_acnt_i(ld_acnt_i), .ld_bcnt_i(ld_bcnt_i), .ld_ccnt_i(ld_ccnt_i),
    .ld_src_bstep_i(ld_sb), .ld_dst_bstep_i(ld_db),
    .ld_src_cstep_i(ld_sc), .ld_dst_cstep_i(ld_dc),
    .ld_static_i(ld_static_i), .ld_mid_en_i(ld_mid_i), .ld_end_en_i(ld_end_i),
    .sync_i(sync_i), .req_valid_o(req_valid_o), .req_src_o(req_src_o),
    .req_dst_o(req_dst_o), .req_bytes_o(req_bytes_o), .frame_done_o(frame_done_o),
    .xfer_done_o(xfer_done_o), .frames_left_o(frames_left_o), .busy_o(busy_o)
  );

  typedef struct {
    int          kind;
    logic [31:0] s, d;
    logic [15:0] n;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_src, m_dst;
  logic [15:0] m_a, m_b, m_c, m_sb, m_db, m_sc, m_dc;
  bit          m_st, m_mid, m_end;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input int k, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] n, input string tag);
    item_t it;
    it.kind = k; it.s = s; it.d = d; it.n = n; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic pop_cmp(input int k, input logic [31:0] s, input logic [31:0] d, input logic [15:0] n);
    item_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6 unexpected output item", k, 99);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, {e.tag, " item kind"}, k, e.kind);
      if (e.kind == 0 && k == 0) begin
        check(s == e.s, {e.tag, " src"}, s, e.s);
        check(d == e.d, {e.tag, " dst"}, d, e.d);
        check(n == e.n, "R2 bytes", n, e.n);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (req_valid_o) pop_cmp(0, req_src_o, req_dst_o, req_bytes_o);
      if (frame_done_o) pop_cmp(1, '0, '0, '0);
      if (xfer_done_o) pop_cmp(2, '0, '0, '0);
    end
  end

  task automatic expect_frame();
    bit last;
    if (m_a == 0 || m_b == 0 || m_c == 0) begin
      if (m_end) push(2, '0, '0, '0, "R8 zero-count done");
    end else begin
      for (int r = 0; r < int'(m_b); r++)
        push(0, m_src + 32'(r) * sx(m_sb), m_dst + 32'(r) * sx(m_db), m_a, "R3 row address");
      last = (m_c == 1);
      if (last && m_end) push(2, '0, '0, '0, "R6 final done");
      if (!last && m_mid) push(1, '0, '0, '0, "R5 frame done");
      if (!m_st) begin
        m_src = m_src + sx(m_sc);
        m_dst = m_dst + sx(m_dc);
        m_c   = m_c - 1;
      end
    end
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] c, input logic [15:0] sb,
                      input logic [15:0] db, input logic [15:0] sc, input logic [15:0] dc,
                      input bit st, input bit mid, input bit en, input bit model);
    @(negedge clk);
    ld_i = 1'b1; ld_src_i = s; ld_dst_i = d; ld_acnt_i = a; ld_bcnt_i = b; ld_ccnt_i = c;
    ld_sb = sb; ld_db = db; ld_sc = sc; ld_dc = dc;
    ld_static_i = st; ld_mid_i = mid; ld_end_i = en;
    if (model) begin
      m_src = s; m_dst = d; m_a = a; m_b = b; m_c = c;
      m_sb = sb; m_db = db; m_sc = sc; m_dc = dc; m_st = st; m_mid = mid; m_end = en;
    end
    @(negedge clk);
    ld_i = 1'b0;
  endtask

  task automatic do_sync(input bit push_exp);
    @(negedge clk);
    sync_i = 1'b1;
    if (push_exp) expect_frame();
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] base_s;
    repeat (3) @(negedge clk);
    check(req_valid_o == 0, "R10 no request", req_valid_o, 0);
    check(busy_o == 0, "R10 idle", busy_o, 0);
    check(frames_left_o == 0, "R10 frames_left", frames_left_o, 0);
    check(!frame_done_o && !xfer_done_o, "R10 no pulse", {frame_done_o, xfer_done_o}, 0);
    rst_n = 1'b1;

    load(32'h1000, 32'h8000, 16'd4, 16'd3, 16'd3, 16'd16, 16'hFFF8, 16'h0100, 16'hFFC0, 0, 1, 1, 1);
    check(frames_left_o == 3, "R1 stored C count", frames_left_o, 3);
    for (int f = 0; f < 3; f++) begin
      do_sync(1);
      wait_idle();
      check(frames_left_o == m_c, "R4 frame count decrements", frames_left_o, m_c);
    end
    do_sync(1);
    wait_idle();

    load(32'h2000, 32'h3000, 16'd8, 16'd4, 16'd4, 16'd8, 16'd8, 16'h0040, 16'h0040, 0, 1, 1, 1);
    do_sync(1);
    do_sync(1);
    do_sync(0);
    wait_idle();
    check(frames_left_o == 2, "R9 merged pending syncs", frames_left_o, 2);

    load(32'h4000, 32'h5000, 16'd2, 16'd2, 16'd3, 16'd4, 16'd4, 16'h0100, 16'h0100, 1, 1, 1, 1);
    do_sync(1);
    wait_idle();
    do_sync(1);
    wait_idle();
    check(frames_left_o == 3, "R7 static count kept", frames_left_o, 3);

    load(32'h6000, 32'h7000, 16'd0, 16'd5, 16'd2, 16'd4, 16'd4, 16'd0, 16'd0, 0, 1, 1, 1);
    do_sync(1);
    wait_idle();
    check(frames_left_o == 2, "R8 zero count no update", frames_left_o, 2);

    load(32'h0000_0010, 32'hFFFF_FFF0, 16'd1, 16'd3, 16'd2, 16'hFFF0, 16'h0008, 16'h8000, 16'h7FFF, 0, 0, 0, 1);
    do_sync(1);
    wait_idle();
    do_sync(1);
    wait_idle();

    load(32'hA000, 32'hB000, 16'd16, 16'd4, 16'd2, 16'd32, 16'd32, 16'h0200, 16'h0200, 0, 1, 1, 1);
    base_s = m_src;
    @(negedge clk);
    sync_i = 1'b1;
    expect_frame();
    @(negedge clk);
    sync_i = 1'b0;
    check(req_valid_o == 1, "R2 first request latency", req_valid_o, 1);
    check(req_src_o == base_s, "R2 first request address", req_src_o, base_s);
    ld_i = 1'b1; ld_ccnt_i = 16'd9; ld_src_i = 32'hDEAD_0000;
    @(negedge clk);
    ld_i = 1'b0;
    wait_idle();
    check(frames_left_o == m_c, "R1 load while busy ignored", frames_left_o, m_c);
    do_sync(1);
    wait_idle();

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected items seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule